// File: doc/BRIEF.md
# Global Exponent Alignment Scheduler

This controller sits in front of a bank of carry-save multipliers and one carry-save accumulator that together form a floating-point sum-of-products engine. The engine keeps one shared exponent for the running sum. The scheduler does not store an absolute exponent for each product in flight. Instead, every multiplier unit and the accumulator hold a small shift counter. The counter says how many bit positions that unit must still move its carry-save value to the right before its value lines up with the shared exponent.

For each accepted operand pair, the scheduler forms the product exponent from the two biased operand exponents. It hands the pair to the next unit in rotation and compares the product exponent with the shared exponent. When the product is smaller, the scheduler loads the chosen unit's counter with the difference. When the product is at least as large, the product becomes the new reference and the scheduler tells every other counter to grow by the difference. A rescale request from the accumulator, raised when its sum is about to overflow, moves the shared exponent up by one and tells every counter to grow by one.

The scheduler also paces issue. It enforces a minimum spacing between issues and holds off a unit that is still working on its previous product. It keeps a copy of each unit's pending shift so that it can tell a unit to drop its contribution once that contribution has been shifted out entirely.

Top module: `align_sched`

## Requirements
- R1: After reset, `issue_ready` is 1, `global_valid` is 0, and the `unit_load`, `unit_inc`, `unit_zero`, `unit_done`, `acc_inc` and `acc_flush` outputs are all 0.
- R2: The product exponent is `exp_a + exp_b - EXP_BIAS`. The first accepted issue after reset makes that value the global exponent, sets `global_valid` on the next edge, loads the assigned unit with shift 0, and raises no increment strobe.
- R3: When delta = global exponent minus product exponent is positive, the assigned unit's bit of `unit_load` is 1 with `load_shift` = delta. The global exponent keeps its value, and no increment strobe is raised.
- R4: When delta is zero or negative, the global exponent becomes the product exponent on the next edge. Every unit other than the assigned one, plus the accumulator, receives an increment of -delta through `unit_inc`, `acc_inc` and `inc_shift`. When delta is 0, no increment strobe is raised.
- R5: When delta is 16 or more (more than 2^CNT_W - 1), the assigned unit is loaded with shift 15. In the same cycle it receives a `unit_zero` strobe.
- R6: Accepted issues go to units 0, 1, ..., NUM_UNITS-1 in turn and then wrap. `unit_load` is one-hot on an accepted issue and all zero otherwise.
- R7: `issue_ready` is low for ISSUE_GAP-1 cycles after each accepted issue. A request made while `issue_ready` is low is ignored: it raises no strobe and leaves the rotation and the global exponent as they were.
- R8: A loaded unit is busy for LATENCY cycles. Its `unit_done` bit is high in the LATENCY-th cycle after the load. `issue_ready` is low while the next unit in rotation is busy and not in that final cycle.
- R9: A `rescale` pulse on its own raises the global exponent by 1 on the next edge (once it is valid). In the same cycle it raises `unit_inc` for every unit and raises `acc_inc`, with `inc_shift` = 1.
- R10: A `rescale` in the same cycle as an accepted issue is applied first. The issue is compared against the global exponent plus one. The increment sent to the other units is 1 plus the issue's own increment, and the assigned unit gets no increment.
- R11: The copy of each busy unit's pending shift saturates at 15. A busy unit whose shift would pass 15 gets exactly one `unit_zero` strobe. `inc_shift` saturates at 15, and `acc_flush` is high whenever the increment exceeds 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operand pair is offered this cycle |
| exp_a | input | EXP_W | Biased exponent of the first operand |
| exp_b | input | EXP_W | Biased exponent of the second operand |
| rescale | input | 1 | Overflow rescale request from the accumulator |
| issue_ready | output | 1 | An offered pair is accepted this cycle |
| unit_load | output | NUM_UNITS | Load strobe, one bit for each multiplier counter |
| load_shift | output | CNT_W | Shift value for the unit being loaded |
| unit_inc | output | NUM_UNITS | Increment strobe, one bit for each multiplier counter |
| inc_shift | output | CNT_W | Increment amount, saturated |
| unit_zero | output | NUM_UNITS | Tells a unit to zero its contribution |
| unit_done | output | NUM_UNITS | Unit's product completes this cycle |
| acc_inc | output | 1 | Increment strobe for the accumulator counter |
| acc_flush | output | 1 | Increment exceeds the counter range |
| global_exp | output | EXP_W+2 | Global exponent, two's complement |
| global_valid | output | 1 | Global exponent has been seeded |

## Verification
The bench builds the scheduler with four units, an issue gap of 2 and a latency of 12 cycles. With these values a full round of issues comes back to the first unit before it has finished. This is the only way the busy hold-off in R8 can be reached: at the default eight units the round length exactly matches the latency. An 8-bit exponent with a bias of 64 and 4-bit counters keep the operand exponents small. That lets one scenario push a unit's shift copy past 15, drive a single increment above 15, and hit both the delta-of-16 load and the rescale-plus-issue ordering. A stretch of random traffic then follows, with the rotation wrapping many times.

// File: rtl/align_sched_pkg.sv
package align_sched_pkg;

  // Outcome of comparing a new product exponent with the shared one
  typedef enum logic [1:0] {
    DEC_SEED   = 2'd0,  // no shared exponent yet, product seeds it
    DEC_BEHIND = 2'd1,  // product smaller, its own unit shifts
    DEC_AHEAD  = 2'd2   // product not smaller, everyone else shifts
  } dec_e;

endpackage

// File: rtl/align_sched_expcmp.sv
module align_sched_expcmp
  import align_sched_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int EXP_BIAS = 64,
  parameter int CNT_W    = 4
) (
  input  logic [EXP_W-1:0] exp_a,
  input  logic [EXP_W-1:0] exp_b,
  input  logic [EXP_W+1:0] glob_q,
  input  logic             glob_ok,
  input  logic             rescale,
  output logic [EXP_W+1:0] glob_adj,
  output logic [EXP_W+1:0] prod_exp,
  output dec_e             dec,
  output logic [CNT_W-1:0] load_val,
  output logic             load_kill,
  output logic [EXP_W+2:0] lift
);
  localparam int GW    = EXP_W + 2;
  localparam int DW    = EXP_W + 3;
  localparam int MAXSH = (1 << CNT_W) - 1;

  logic signed [DW-1:0] pe_s;
  logic signed [DW-1:0] ga_s;
  logic signed [DW-1:0] d_s;

  always_comb begin
    // rescale first, so a same-cycle issue sees the raised exponent
    glob_adj = (glob_ok && rescale) ? glob_q + GW'(1) : glob_q;
    pe_s     = $signed({3'b000, exp_a}) + $signed({3'b000, exp_b})
             - $signed(DW'(EXP_BIAS));
    prod_exp = pe_s[GW-1:0];
    ga_s     = $signed({glob_adj[GW-1], glob_adj});
    d_s      = ga_s - pe_s;

    dec       = DEC_SEED;
    load_val  = '0;
    load_kill = 1'b0;
    lift      = '0;
    if (glob_ok) begin
      if (d_s > 0) begin
        dec       = DEC_BEHIND;
        load_kill = (d_s > MAXSH);
        load_val  = load_kill ? CNT_W'(MAXSH) : d_s[CNT_W-1:0];
      end else begin
        dec  = DEC_AHEAD;
        lift = -d_s;
      end
    end
  end

endmodule

// File: rtl/align_sched_slot.sv
module align_sched_slot #(
  parameter int CNT_W   = 4,
  parameter int LATENCY = 16,
  parameter int AW      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_kill,
  input  logic             inc,
  input  logic [AW-1:0]    inc_amt,
  output logic             busy,
  output logic             done,
  output logic             zero
);
  localparam int TW    = $clog2(LATENCY + 1);
  localparam int SW    = AW + 1;
  localparam int MAXSH = (1 << CNT_W) - 1;

  logic [TW-1:0]    tmr_q, tmr_d;
  logic [CNT_W-1:0] shf_q, shf_d;
  logic             dead_q, dead_d;
  logic [SW-1:0]    sum;
  logic             over;
  logic             st_en;

  always_comb begin
    busy   = (tmr_q != '0);
    done   = (tmr_q == TW'(1));
    sum    = {1'b0, inc_amt} + SW'(shf_q);
    over   = (sum > SW'(MAXSH));
    tmr_d  = tmr_q;
    shf_d  = shf_q;
    dead_d = dead_q;
    zero   = 1'b0;
    if (load) begin
      tmr_d  = TW'(LATENCY);
      shf_d  = load_val;
      dead_d = load_kill;
      zero   = load_kill;
    end else begin
      if (busy) tmr_d = tmr_q - TW'(1);
      if (inc && busy) begin
        shf_d = over ? CNT_W'(MAXSH) : sum[CNT_W-1:0];
        if (over && !dead_q) begin
          zero   = 1'b1;
          dead_d = 1'b1;
        end
      end
    end
    st_en = load || busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      shf_q  <= '0;
      dead_q <= 1'b0;
    end else if (st_en) begin
      tmr_q  <= tmr_d;
      shf_q  <= shf_d;
      dead_q <= dead_d;
    end
  end

  // R8: a unit is only loaded when free or in its final cycle
  a_r8_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (tmr_q <= TW'(1)));

  // R8: the completion cycle is the last busy cycle
  a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy);

  // R11: a dropped unit is never told to drop again before reload
  a_r11_zero_once: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> (!zero || load));

endmodule

// File: rtl/align_sched.sv
module align_sched
  import align_sched_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int EXP_W     = 8,
  parameter int EXP_BIAS  = 64,
  parameter int CNT_W     = 4,
  parameter int LATENCY   = 16,
  parameter int ISSUE_GAP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic [EXP_W-1:0]     exp_a,
  input  logic [EXP_W-1:0]     exp_b,
  input  logic                 rescale,
  output logic                 issue_ready,
  output logic [NUM_UNITS-1:0] unit_load,
  output logic [CNT_W-1:0]     load_shift,
  output logic [NUM_UNITS-1:0] unit_inc,
  output logic [CNT_W-1:0]     inc_shift,
  output logic [NUM_UNITS-1:0] unit_zero,
  output logic [NUM_UNITS-1:0] unit_done,
  output logic                 acc_inc,
  output logic                 acc_flush,
  output logic [EXP_W+1:0]     global_exp,
  output logic                 global_valid
);
  localparam int PW    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int GW    = EXP_W + 2;
  localparam int DW    = EXP_W + 3;
  localparam int GAPW  = $clog2(ISSUE_GAP + 1);
  localparam int MAXSH = (1 << CNT_W) - 1;

  logic [PW-1:0]        ptr_q, ptr_d;
  logic [GAPW-1:0]      gap_q, gap_d;
  logic [GW-1:0]        glob_q, glob_d;
  logic                 gvalid_q, gvalid_d;

  logic [GW-1:0]        glob_adj, prod_exp;
  dec_e                 dec;
  logic [CNT_W-1:0]     load_val;
  logic                 load_kill;
  logic [DW-1:0]        lift, total;
  logic                 accept;
  logic [NUM_UNITS-1:0] slot_busy;

  align_sched_expcmp #(
    .EXP_W(EXP_W), .EXP_BIAS(EXP_BIAS), .CNT_W(CNT_W)
  ) u_cmp (
    .exp_a(exp_a), .exp_b(exp_b), .glob_q(glob_q), .glob_ok(gvalid_q),
    .rescale(rescale), .glob_adj(glob_adj), .prod_exp(prod_exp),
    .dec(dec), .load_val(load_val), .load_kill(load_kill), .lift(lift)
  );

  // issue pacing and broadcast strobes
  always_comb begin
    issue_ready = (gap_q == '0) && (!slot_busy[ptr_q] || unit_done[ptr_q]);
    accept      = issue_valid && issue_ready;
    total       = (accept ? lift : '0) + DW'(rescale);
    unit_load   = accept ? (NUM_UNITS'(1) << ptr_q) : '0;
    load_shift  = load_val;
    acc_inc     = (total != '0);
    acc_flush   = (total > DW'(MAXSH));
    unit_inc    = acc_inc ? ~unit_load : '0;
    inc_shift   = acc_flush ? CNT_W'(MAXSH) : total[CNT_W-1:0];
  end

  always_comb begin
    ptr_d    = ptr_q;
    gap_d    = (gap_q != '0) ? gap_q - GAPW'(1) : gap_q;
    glob_d   = glob_adj;
    gvalid_d = gvalid_q | accept;
    if (accept) begin
      ptr_d = (ptr_q == PW'(NUM_UNITS - 1)) ? '0 : ptr_q + PW'(1);
      gap_d = GAPW'(ISSUE_GAP - 1);
      if (dec != DEC_BEHIND) glob_d = prod_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      gap_q    <= '0;
      glob_q   <= '0;
      gvalid_q <= 1'b0;
    end else begin
      if (accept)                  ptr_q  <= ptr_d;
      if (accept || gap_q != '0)   gap_q  <= gap_d;
      if (accept || rescale)       glob_q <= glob_d;
      gvalid_q <= gvalid_d;
    end
  end

  assign global_exp   = glob_q;
  assign global_valid = gvalid_q;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_slot
    align_sched_slot #(
      .CNT_W(CNT_W), .LATENCY(LATENCY), .AW(DW)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(unit_load[k]), .load_val(load_val), .load_kill(load_kill),
      .inc(unit_inc[k]), .inc_amt(total),
      .busy(slot_busy[k]), .done(unit_done[k]), .zero(unit_zero[k])
    );
  end

  // R6: at most one unit loaded per cycle
  a_r6_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_load));

  // R9: a lone rescale raises the seeded exponent by one
  a_r9_rescale_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rescale && gvalid_q && !accept) |=> (global_exp == GW'($past(global_exp) + 1)));

  // R3: a smaller product leaves the shared exponent alone
  a_r3_behind_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rescale && dec == DEC_BEHIND) |=> $stable(global_exp));

  // R2: the first accepted issue seeds the shared exponent
  a_r2_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gvalid_q) |=> (global_valid && global_exp == $past(prod_exp)));

  if (ISSUE_GAP > 1) begin : g_gap_chk
    // R7: spacing enforced after every accepted issue
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !issue_ready);
  end

endmodule

// File: tb/align_sched_bench.sv
module align_sched_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB   = 4;
  localparam int EW   = 8;
  localparam int BIAS = 64;
  localparam int CW   = 4;
  localparam int LAT  = 12;
  localparam int GAP  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic [EW-1:0] exp_a = '0, exp_b = '0;
  logic          rescale = 1'b0;
  logic          issue_ready;
  logic [NB-1:0] unit_load, unit_inc, unit_zero, unit_done;
  logic [CW-1:0] load_shift, inc_shift;
  logic          acc_inc, acc_flush;
  logic [EW+1:0] global_exp;
  logic          global_valid;

  always #4 clk = ~clk;

  align_sched #(
    .NUM_UNITS(NB), .EXP_W(EW), .EXP_BIAS(BIAS), .CNT_W(CW),
    .LATENCY(LAT), .ISSUE_GAP(GAP)
  ) u_align_sched (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .exp_a(exp_a),
    .exp_b(exp_b), .rescale(rescale), .issue_ready(issue_ready),
    .unit_load(unit_load), .load_shift(load_shift), .unit_inc(unit_inc),
    .inc_shift(inc_shift), .unit_zero(unit_zero), .unit_done(unit_done),
    .acc_inc(acc_inc), .acc_flush(acc_flush), .global_exp(global_exp),
    .global_valid(global_valid)
  );

  typedef struct {
    bit         rdy;
    bit [NB-1:0] ld, inc, zr, dn;
    int         ldv, incv;
    bit         ai, af, gv;
    int         g;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit all_done = 0;

  // reference state, built from the requirements
  int m_g = 0, m_ptr = 0, m_gap = 0;
  bit m_gv = 0;
  int m_tmr[NB], m_shf[NB];
  bit m_dead[NB];

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic drive(bit iv, int ea, int eb, bit rs, string tag);
    exp_t e;
    int pe, g1, d, total, ng, s;
    bit acc, lk;
    @(negedge clk);
    issue_valid = iv; exp_a = EW'(ea); exp_b = EW'(eb); rescale = rs;
    e.tag = tag;
    e.rdy = (m_gap == 0) && (m_tmr[m_ptr] <= 1);
    acc   = iv && e.rdy;
    pe    = ea + eb - BIAS;
    g1    = (m_gv && rs) ? m_g + 1 : m_g;
    e.ld = '0; e.zr = '0; e.dn = '0; e.ldv = 0; lk = 0;
    total = rs ? 1 : 0;
    ng = g1;
    if (acc) begin
      e.ld[m_ptr] = 1'b1;
      if (!m_gv) ng = pe;
      else begin
        d = g1 - pe;
        if (d > 0) begin
          e.ldv = (d > 15) ? 15 : d;
          lk = (d > 15);
        end else begin
          total += -d;
          ng = pe;
        end
      end
    end
    e.ai   = (total != 0);
    e.af   = (total > 15);
    e.inc  = e.ai ? ~e.ld : '0;
    e.incv = (total > 15) ? 15 : total;
    for (int k = 0; k < NB; k++) begin
      e.dn[k] = (m_tmr[k] == 1);
      if (e.ld[k]) e.zr[k] = lk;
      else if (total != 0 && m_tmr[k] != 0 && !m_dead[k] && m_shf[k] + total > 15)
        e.zr[k] = 1'b1;
    end
    e.g = m_g; e.gv = m_gv;
    q.push_back(e);
    // advance reference state
    for (int k = 0; k < NB; k++) begin
      if (e.ld[k]) begin
        m_tmr[k] = LAT; m_shf[k] = e.ldv; m_dead[k] = lk;
      end else begin
        if (m_tmr[k] != 0 && total != 0) begin
          s = m_shf[k] + total;
          m_shf[k] = (s > 15) ? 15 : s;
          if (e.zr[k]) m_dead[k] = 1;
        end
        if (m_tmr[k] != 0) m_tmr[k]--;
      end
    end
    if (acc) begin
      m_ptr = (m_ptr + 1) % NB;
      m_gap = GAP - 1;
    end else if (m_gap > 0) m_gap--;
    m_g = ng;
    m_gv = m_gv | acc;
  endtask

  // monitor: compare each expected item with the outputs before the edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() != 0) begin
        e = q.pop_front();
        chk(e.tag, "issue_ready", int'(issue_ready), int'(e.rdy));
        chk(e.tag, "unit_load", int'(unit_load), int'(e.ld));
        if (e.ld != 0) chk(e.tag, "load_shift", int'(load_shift), e.ldv);
        chk(e.tag, "unit_inc", int'(unit_inc), int'(e.inc));
        chk(e.tag, "acc_inc", int'(acc_inc), int'(e.ai));
        if (e.ai) chk(e.tag, "inc_shift", int'(inc_shift), e.incv);
        chk(e.tag, "acc_flush", int'(acc_flush), int'(e.af));
        chk(e.tag, "unit_zero", int'(unit_zero), int'(e.zr));
        chk(e.tag, "unit_done", int'(unit_done), int'(e.dn));
        chk(e.tag, "global_valid", int'(global_valid), int'(e.gv));
        if (e.gv) chk(e.tag, "global_exp", int'($signed(global_exp)), e.g);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!all_done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NB; k++) begin
      m_tmr[k] = 0; m_shf[k] = 0; m_dead[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle state after reset
    drive(0, 0, 0, 0, "R1");
    drive(0, 0, 0, 0, "R1");
    // R2: seed with 70+60-64 = 66
    drive(1, 70, 60, 0, "R2");
    // R7: request during the gap is ignored
    drive(1, 90, 90, 0, "R7");
    // R3: product 60, delta 6
    drive(1, 64, 60, 0, "R3");
    drive(0, 0, 0, 0, "R7");
    // R4: product 70, delta -4
    drive(1, 64, 70, 0, "R4");
    drive(0, 0, 0, 0, "R4");
    // R5: product 50, delta 20
    drive(1, 64, 50, 0, "R5");
    drive(0, 0, 0, 0, "R5");
    // R8: rotation back on unit 0 which is still busy
    repeat (4) drive(1, 64, 80, 0, "R8");
    // R11: accepted at last, delta -10 pushes unit 1 past 15
    drive(1, 64, 80, 0, "R11");
    drive(0, 0, 0, 0, "R6");
    // R9: lone rescale
    drive(0, 0, 0, 1, "R9");
    drive(0, 0, 0, 0, "R9");
    // R10: rescale together with a same-exponent issue
    drive(1, 64, 81, 1, "R10");
    drive(0, 0, 0, 0, "R10");
    // R10: rescale with a product exactly one above
    drive(1, 64, 83, 1, "R10");
    drive(0, 0, 0, 0, "R4");
    // R11: increment above 15 flushes the accumulator
    drive(1, 100, 100, 0, "R11");
    // R6: random traffic, rotation wraps many times
    for (int i = 0; i < 300; i++)
      drive(($urandom_range(0, 9) < 7), $urandom_range(55, 75),
            $urandom_range(55, 75), ($urandom_range(0, 9) == 0), "R6");
    // R8: drain and see every completion strobe
    repeat (LAT + 3) drive(0, 0, 0, 0, "R8");
    @(negedge clk);
    #5;
    all_done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule